// File: doc/BRIEF.md
# Remote Read Unrolling Backend

This block sits at the edge of a many-core die, beside the network router. Per-core frontends hand it remote-read requests. Each request names a remote base address, a local base address and a length in cache blocks. The backend keeps each accepted request in one of eight slots. It splits the request into single-block network reads and sends them out, one per cycle. Every network read carries the slot index and the block offset, so a reply can find its way home whatever order replies arrive in.

Each reply is turned into a one-block write toward the last-level cache, at the local base plus the reply's offset. A slot finishes once its reply count reaches zero. The backend then sends a completion packet, addressed to the frontend that made the request and carrying that frontend's tag. The frontend then posts its own completion entry. The slot is released on the same clock edge on which the completion packet is accepted. While all eight slots are in use, new requests are held off.

Top module: `rub_backend`

## Requirements
- R1: After reset, `fe_req_ready` is 1 and `net_rd_valid`, `llc_wr_valid` and `cpl_valid` are 0.
- R2: A request of N blocks (N ≥ 1) produces exactly N network reads. Their offsets `net_rd_off` run 0, 1, …, N-1 in order. The address of each is `raddr + off*64`, and each carries the slot index of the request in `net_rd_slot`.
- R3: At most one network read is transferred per cycle. While `net_rd_valid` is 1 and `net_rd_ready` is 0, the address, slot and offset stay unchanged.
- R4: Every reply, whatever its order, produces exactly one LLC write in the following cycle. The write address is `laddr + off*64` of the slot named by `net_rsp_slot`, and the write data is the reply data.
- R5: A completion is raised only after the last reply of the request has been received. It carries `cpl_dst` = the source frontend id and `cpl_tag` = the request tag. Once raised, it is held unchanged until `cpl_ready` is 1, even if another slot finishes meanwhile.
- R6: While eight requests are outstanding, `fe_req_ready` is 0.
- R7: A request with a block count of 0 produces a completion and no network read.
- R8: A slot is released on the clock edge on which its completion is accepted. The next request may then take that slot.
- R9: A new request takes the lowest free slot index. Among slots with blocks still to send, the lowest index issues first. Among finished slots, the lowest index completes first, unless a completion is already stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fe_req_valid | input | 1 | Frontend request present |
| fe_req_ready | output | 1 | A free slot exists; request accepted when valid |
| fe_req_src | input | 4 | Id of the requesting frontend |
| fe_req_tag | input | 8 | Frontend's own request tag |
| fe_req_raddr | input | 40 | Remote base byte address |
| fe_req_laddr | input | 40 | Local base byte address |
| fe_req_nblk | input | 6 | Number of cache blocks (0 to 63) |
| net_rd_valid | output | 1 | Network block read present |
| net_rd_ready | input | 1 | Router accepts the read |
| net_rd_addr | output | 40 | Remote block address |
| net_rd_slot | output | 3 | Slot index carried for the reply |
| net_rd_off | output | 6 | Block offset carried for the reply |
| net_rsp_valid | input | 1 | Network reply present (always taken) |
| net_rsp_slot | input | 3 | Slot index echoed by the reply |
| net_rsp_off | input | 6 | Block offset echoed by the reply |
| net_rsp_data | input | 512 | One cache block of payload |
| llc_wr_valid | output | 1 | LLC block write present |
| llc_wr_addr | output | 40 | Local block address |
| llc_wr_data | output | 512 | Block payload |
| cpl_valid | output | 1 | Completion packet present |
| cpl_ready | input | 1 | On-chip network accepts the completion |
| cpl_dst | output | 4 | Destination frontend id |
| cpl_tag | output | 8 | Tag of the finished request |

## Verification
The in-line assertions watch several rules on every cycle. They check that a stalled read or completion holds its fields, and that allocation never lands on a busy slot. They check that a slot is released only when it has finished, that every reply names a live slot with a block already sent, and that each reply is followed by one LLC write. They also check that a read offset stays below the request's length. The directed scenarios cover what needs a whole transaction to see: exact read addresses and ordering, reverse-order replies landing at the right local addresses, no early completion, zero-length requests, the stall at eight outstanding requests, and slot reuse by index.

// File: rtl/rub_pkg.sv
`timescale 1ns/1ps
// Shared configuration, slot record and address helper for the unrolling backend.
// Assumes power-of-two block size and a slot count that fits IDX_W bits.
package rub_pkg;
    localparam int SLOTS      = 8;
    localparam int IDX_W      = $clog2(SLOTS);
    localparam int FE_W       = 4;
    localparam int TAG_W      = 8;
    localparam int ADDR_W     = 40;
    localparam int CNT_W      = 6;
    localparam int BLK_BYTES  = 64;
    localparam int BLK_SHIFT  = $clog2(BLK_BYTES);
    localparam int BLK_DATA_W = BLK_BYTES * 8;

    typedef struct packed {
        logic [FE_W-1:0]   src;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] raddr;
        logic [ADDR_W-1:0] laddr;
        logic [CNT_W-1:0]  nblk;
    } slot_rec_t;

    // Byte address of block 'off' relative to 'base'.
    function automatic logic [ADDR_W-1:0] blk_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [CNT_W-1:0]  off);
        return base + (ADDR_W'(off) << BLK_SHIFT);
    endfunction
endpackage

// File: rtl/rub_pick_first.sv
`timescale 1ns/1ps
// Fixed-priority picker: reports whether any request bit is set and the lowest set index.
// Assumes N is at least 2. Purely combinational.
module rub_pick_first #(
    parameter int N   = 8,
    localparam int W  = $clog2(N)
) (
    input  logic [N-1:0] cand,
    output logic         any,
    output logic [W-1:0] idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) idx = W'(i);
        end
        any = |cand;
    end
endmodule

// File: rtl/rub_hold_pick.sv
`timescale 1ns/1ps
// Picks the lowest candidate slot for an output channel and, once that channel is
// stalled, keeps the same slot until it is taken, so the offered fields stay put.
// Assumes a candidate stays a candidate until it fires.
module rub_hold_pick #(
    parameter int N   = 8,
    localparam int W  = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cand,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] idx,
    output logic         fire
);
    logic         pick_any;
    logic [W-1:0] pick_idx;
    logic         hold_q;
    logic [W-1:0] hold_idx_q;

    rub_pick_first #(.N(N)) u_pick (
        .cand (cand),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    // Present the held slot while stalled, else the lowest candidate.
    always_comb begin
        idx   = hold_q ? hold_idx_q : pick_idx;
        valid = hold_q | pick_any;
        fire  = valid & ready;
    end

    // Remember a stalled offer for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q     <= 1'b0;
            hold_idx_q <= '0;
        end else begin
            hold_q     <= valid & ~ready;
            hold_idx_q <= idx;
        end
    end

    // R3/R5: a stalled offer keeps its slot on the next cycle.
    a_r3_r5_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready |=> valid && (idx == $past(idx)));

    // The offered slot is always a live candidate.
    a_r9_offer_is_cand: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> cand[idx]);
endmodule

// File: rtl/rub_slot_table.sv
`timescale 1ns/1ps
// Outstanding-request table: one entry per slot holding the request record, the
// number of blocks already sent and the number of replies still expected.
// Assumes allocation targets a free slot and replies only name live slots.
module rub_slot_table
    import rub_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [IDX_W-1:0] alloc_idx,
    input  slot_rec_t        alloc_rec,
    input  logic             issue_en,
    input  logic [IDX_W-1:0] issue_idx,
    input  logic             rsp_en,
    input  logic [IDX_W-1:0] rsp_idx,
    input  logic             free_en,
    input  logic [IDX_W-1:0] free_idx,
    output logic [SLOTS-1:0] busy,
    output logic [SLOTS-1:0] pend,
    output logic [SLOTS-1:0] done,
    output slot_rec_t        rec  [SLOTS],
    output logic [CNT_W-1:0] sent [SLOTS]
);
    logic [CNT_W-1:0] left [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        // Per-slot state: allocate, count issued blocks, count down replies, release.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[g] <= 1'b0;
                rec[g]  <= '0;
                sent[g] <= '0;
                left[g] <= '0;
            end else if (alloc_en && alloc_idx == IDX_W'(g)) begin
                busy[g] <= 1'b1;
                rec[g]  <= alloc_rec;
                sent[g] <= '0;
                left[g] <= alloc_rec.nblk;
            end else begin
                if (free_en && free_idx == IDX_W'(g)) busy[g] <= 1'b0;
                if (issue_en && issue_idx == IDX_W'(g)) sent[g] <= sent[g] + 1'b1;
                if (rsp_en && rsp_idx == IDX_W'(g) && left[g] != '0) left[g] <= left[g] - 1'b1;
            end
        end

        // Slot status flags for the two output pickers.
        always_comb begin
            pend[g] = busy[g] && (sent[g] != rec[g].nblk);
            done[g] = busy[g] && (sent[g] == rec[g].nblk) && (left[g] == '0);
        end
    end

    // R9: allocation never lands on a busy slot.
    a_r9_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !busy[alloc_idx]);

    // R8: a slot is released only once it has finished.
    a_r8_free_done: assert property (@(posedge clk) disable iff (!rst_n)
        free_en |-> done[free_idx]);

    // R4: a reply names a live slot and a block that has already been sent.
    a_r4_rsp_known: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_en |-> busy[rsp_idx] && ((rec[rsp_idx].nblk - left[rsp_idx]) < sent[rsp_idx]));
endmodule

// File: rtl/rub_llc_writer.sv
`timescale 1ns/1ps
// Turns each network reply into a registered one-block write toward the LLC.
// Assumes the LLC write port always accepts.
module rub_llc_writer
    import rub_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rsp_valid,
    input  logic [ADDR_W-1:0]     rsp_base,
    input  logic [CNT_W-1:0]      rsp_off,
    input  logic [BLK_DATA_W-1:0] rsp_data,
    output logic                  wr_valid,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [BLK_DATA_W-1:0] wr_data
);
    // Register the write one cycle after the reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= rsp_valid;
            if (rsp_valid) begin
                wr_addr <= blk_addr(rsp_base, rsp_off);
                wr_data <= rsp_data;
            end
        end
    end

    // R4: every reply yields exactly one write on the next cycle.
    a_r4_wr_next: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> wr_valid);
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |=> !wr_valid);
endmodule

// File: rtl/rub_backend.sv
`timescale 1ns/1ps
// Edge backend for remote reads: accepts requests into free slots, unrolls them into
// single-block network reads, writes replies to the LLC and returns a completion
// to the requesting frontend once every reply for a slot has arrived.
// Assumes replies echo slot and offset of a read that was sent.
module rub_backend
    import rub_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fe_req_valid,
    output logic                  fe_req_ready,
    input  logic [FE_W-1:0]       fe_req_src,
    input  logic [TAG_W-1:0]      fe_req_tag,
    input  logic [ADDR_W-1:0]     fe_req_raddr,
    input  logic [ADDR_W-1:0]     fe_req_laddr,
    input  logic [CNT_W-1:0]      fe_req_nblk,
    output logic                  net_rd_valid,
    input  logic                  net_rd_ready,
    output logic [ADDR_W-1:0]     net_rd_addr,
    output logic [IDX_W-1:0]      net_rd_slot,
    output logic [CNT_W-1:0]      net_rd_off,
    input  logic                  net_rsp_valid,
    input  logic [IDX_W-1:0]      net_rsp_slot,
    input  logic [CNT_W-1:0]      net_rsp_off,
    input  logic [BLK_DATA_W-1:0] net_rsp_data,
    output logic                  llc_wr_valid,
    output logic [ADDR_W-1:0]     llc_wr_addr,
    output logic [BLK_DATA_W-1:0] llc_wr_data,
    output logic                  cpl_valid,
    input  logic                  cpl_ready,
    output logic [FE_W-1:0]       cpl_dst,
    output logic [TAG_W-1:0]      cpl_tag
);
    logic [SLOTS-1:0] busy, pend, done;
    slot_rec_t        rec  [SLOTS];
    logic [CNT_W-1:0] sent [SLOTS];
    logic             alloc_any, alloc_en;
    logic [IDX_W-1:0] alloc_idx;
    slot_rec_t        alloc_rec;
    logic             issue_en, free_en;
    logic [IDX_W-1:0] issue_idx, free_idx;

    // Lowest free slot for the next request.
    rub_pick_first #(.N(SLOTS)) u_free_pick (
        .cand (~busy),
        .any  (alloc_any),
        .idx  (alloc_idx)
    );

    // Accept a request whenever a slot is free.
    always_comb begin
        fe_req_ready = alloc_any;
        alloc_en     = fe_req_valid & alloc_any;
        alloc_rec    = '{src: fe_req_src, tag: fe_req_tag, raddr: fe_req_raddr,
                         laddr: fe_req_laddr, nblk: fe_req_nblk};
    end

    rub_slot_table u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc_en),
        .alloc_idx (alloc_idx),
        .alloc_rec (alloc_rec),
        .issue_en  (issue_en),
        .issue_idx (issue_idx),
        .rsp_en    (net_rsp_valid),
        .rsp_idx   (net_rsp_slot),
        .free_en   (free_en),
        .free_idx  (free_idx),
        .busy      (busy),
        .pend      (pend),
        .done      (done),
        .rec       (rec),
        .sent      (sent)
    );

    rub_hold_pick #(.N(SLOTS)) u_issue_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .cand  (pend),
        .ready (net_rd_ready),
        .valid (net_rd_valid),
        .idx   (issue_idx),
        .fire  (issue_en)
    );

    // Form the network read of the selected slot's next block.
    always_comb begin
        net_rd_slot = issue_idx;
        net_rd_off  = sent[issue_idx];
        net_rd_addr = blk_addr(rec[issue_idx].raddr, sent[issue_idx]);
    end

    rub_llc_writer u_writer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rsp_valid (net_rsp_valid),
        .rsp_base  (rec[net_rsp_slot].laddr),
        .rsp_off   (net_rsp_off),
        .rsp_data  (net_rsp_data),
        .wr_valid  (llc_wr_valid),
        .wr_addr   (llc_wr_addr),
        .wr_data   (llc_wr_data)
    );

    rub_hold_pick #(.N(SLOTS)) u_cpl_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .cand  (done),
        .ready (cpl_ready),
        .valid (cpl_valid),
        .idx   (free_idx),
        .fire  (free_en)
    );

    // Completion packet fields come from the finishing slot.
    always_comb begin
        cpl_dst = rec[free_idx].src;
        cpl_tag = rec[free_idx].tag;
    end

    // R3: a stalled network read keeps its fields.
    a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        net_rd_valid && !net_rd_ready |=> net_rd_valid && $stable(net_rd_addr)
            && $stable(net_rd_slot) && $stable(net_rd_off));

    // R5: a stalled completion keeps its fields.
    a_r5_cpl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_dst) && $stable(cpl_tag));

    // R2: an offered offset always lies inside the request.
    a_r2_off_bound: assert property (@(posedge clk) disable iff (!rst_n)
        net_rd_valid |-> net_rd_off < rec[net_rd_slot].nblk);

    // R7: a zero-length slot never offers a read.
    a_r7_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        net_rd_valid |-> rec[net_rd_slot].nblk != '0);
endmodule

// File: tb/rub_backend_tb.sv
`timescale 1ns/1ps
module rub_backend_tb;
    import rub_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic                  fe_req_valid = 0, net_rd_ready = 1, net_rsp_valid = 0, cpl_ready = 1;
    logic                  fe_req_ready, net_rd_valid, llc_wr_valid, cpl_valid;
    logic [FE_W-1:0]       fe_req_src = 0, cpl_dst;
    logic [TAG_W-1:0]      fe_req_tag = 0, cpl_tag;
    logic [ADDR_W-1:0]     fe_req_raddr = 0, fe_req_laddr = 0, net_rd_addr, llc_wr_addr;
    logic [CNT_W-1:0]      fe_req_nblk = 0, net_rd_off, net_rsp_off = 0;
    logic [IDX_W-1:0]      net_rd_slot, net_rsp_slot = 0;
    logic [BLK_DATA_W-1:0] net_rsp_data = 0, llc_wr_data;

    rub_backend u_dut (.*);

    int checks = 0, errors = 0;
    int nr_n = 0, lw_n = 0, cp_n = 0;
    logic [ADDR_W-1:0] nr_addr [64];
    logic [IDX_W-1:0]  nr_slot [64];
    logic [CNT_W-1:0]  nr_off  [64];
    logic [ADDR_W-1:0] lw_addr [64];
    logic [63:0]       lw_data [64];
    logic [FE_W-1:0]   cp_dst  [64];
    logic [TAG_W-1:0]  cp_tag  [64];

    // Log every transfer on the output channels, away from the active edge.
    always @(negedge clk) if (rst_n) begin
        if (net_rd_valid && net_rd_ready && nr_n < 64) begin
            nr_addr[nr_n] = net_rd_addr; nr_slot[nr_n] = net_rd_slot; nr_off[nr_n] = net_rd_off; nr_n++;
        end
        if (llc_wr_valid && lw_n < 64) begin
            lw_addr[lw_n] = llc_wr_addr; lw_data[lw_n] = llc_wr_data[63:0]; lw_n++;
        end
        if (cpl_valid && cpl_ready && cp_n < 64) begin
            cp_dst[cp_n] = cpl_dst; cp_tag[cp_n] = cpl_tag; cp_n++;
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_req(input logic [FE_W-1:0] src, input logic [TAG_W-1:0] tag,
                            input logic [ADDR_W-1:0] ra, input logic [ADDR_W-1:0] la,
                            input logic [CNT_W-1:0] nb);
        @(posedge clk); #1;
        fe_req_src = src; fe_req_tag = tag; fe_req_raddr = ra; fe_req_laddr = la; fe_req_nblk = nb;
        fe_req_valid = 1;
        do @(negedge clk); while (!fe_req_ready);
        @(posedge clk); #1;
        fe_req_valid = 0;
    endtask

    task automatic send_rsp(input int slot, input int off, input logic [63:0] data);
        @(posedge clk); #1;
        net_rsp_valid = 1; net_rsp_slot = IDX_W'(slot); net_rsp_off = CNT_W'(off);
        net_rsp_data = BLK_DATA_W'(data);
        @(posedge clk); #1;
        net_rsp_valid = 0;
    endtask

    task automatic wait_cpl(input int n);
        for (int i = 0; i < 60 && cp_n < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1", "fe_req_ready", 64'(fe_req_ready), 1);
        chk("R1", "net_rd_valid", 64'(net_rd_valid), 0);
        chk("R1", "llc_wr_valid", 64'(llc_wr_valid), 0);
        chk("R1", "cpl_valid", 64'(cpl_valid), 0);
    endtask

    // Four-block read, replies returned in reverse order.
    task automatic t_four_block;
        int b = nr_n, w = lw_n, c = cp_n;
        send_req(4'd3, 8'h11, 40'h10_0000_0000, 40'h20_0000_0000, 6'd4);
        cycles(6);
        chk("R2", "read count", 64'(nr_n - b), 4);
        for (int i = 0; i < 4; i++) begin
            chk("R2", "read off", 64'(nr_off[b+i]), 64'(i));
            chk("R2", "read addr", 64'(nr_addr[b+i]), 64'(40'h10_0000_0000 + i*64));
            chk("R9", "read slot", 64'(nr_slot[b+i]), 0);
        end
        for (int i = 3; i >= 1; i--) send_rsp(0, i, 64'hA0 + 64'(i));
        cycles(3);
        chk("R5", "no early completion", 64'(cp_n - c), 0);
        send_rsp(0, 0, 64'hA0);
        wait_cpl(c + 1);
        chk("R5", "completion count", 64'(cp_n - c), 1);
        chk("R5", "cpl dst", 64'(cp_dst[c]), 3);
        chk("R5", "cpl tag", 64'(cp_tag[c]), 64'h11);
        chk("R4", "write count", 64'(lw_n - w), 4);
        for (int i = 0; i < 4; i++) begin
            chk("R4", "write addr", 64'(lw_addr[w+i]), 64'(40'h20_0000_0000 + (3-i)*64));
            chk("R4", "write data", lw_data[w+i], 64'hA0 + 64'(3-i));
        end
    endtask

    // Router back-pressure on the read channel.
    task automatic t_rd_stall;
        int b = nr_n, c = cp_n;
        logic [ADDR_W-1:0] a0;
        net_rd_ready = 0;
        send_req(4'd1, 8'h31, 40'h00_0000_1000, 40'h00_0008_0000, 6'd3);
        @(negedge clk); a0 = net_rd_addr;
        cycles(3);
        chk("R3", "stalled valid", 64'(net_rd_valid), 1);
        chk("R3", "stalled addr", 64'(net_rd_addr), 64'(a0));
        chk("R3", "stalled off", 64'(net_rd_off), 0);
        chk("R3", "no transfer", 64'(nr_n - b), 0);
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1; net_rd_ready = ~net_rd_ready;
        end
        @(posedge clk); #1; net_rd_ready = 1;
        cycles(4);
        chk("R3", "read count", 64'(nr_n - b), 3);
        for (int i = 0; i < 3; i++) chk("R2", "stall off", 64'(nr_off[b+i]), 64'(i));
        for (int i = 0; i < 3; i++) send_rsp(0, i, 64'h5);
        wait_cpl(c + 1);
        chk("R5", "cpl tag", 64'(cp_tag[c]), 64'h31);
    endtask

    // Zero-length request.
    task automatic t_zero;
        int b = nr_n, c = cp_n;
        send_req(4'd5, 8'h55, 40'h0, 40'h0, 6'd0);
        wait_cpl(c + 1);
        cycles(2);
        chk("R7", "completion", 64'(cp_n - c), 1);
        chk("R7", "cpl tag", 64'(cp_tag[c]), 64'h55);
        chk("R7", "no read", 64'(nr_n - b), 0);
    endtask

    // Fill all slots, stall, release one, reuse it.
    task automatic t_fill;
        int b = nr_n, c = cp_n;
        for (int i = 0; i < 8; i++)
            send_req(4'(i), 8'(8'h80 + i), 40'(40'h1_0000 * (i+1)), 40'(40'h2_0000 * (i+1)), 6'd1);
        cycles(2);
        chk("R6", "ready when full", 64'(fe_req_ready), 0);
        for (int i = 0; i < 8; i++) chk("R9", "slot order", 64'(nr_slot[b+i]), 64'(i));
        send_rsp(5, 0, 64'h77);
        wait_cpl(c + 1);
        chk("R8", "released tag", 64'(cp_tag[c]), 64'h85);
        cycles(1);
        chk("R8", "ready after release", 64'(fe_req_ready), 1);
        send_req(4'd9, 8'h99, 40'h9_0000, 40'h9_8000, 6'd1);
        cycles(3);
        chk("R8", "reused slot", 64'(nr_slot[b+8]), 5);
        for (int i = 0; i < 8; i++) send_rsp(i, 0, 64'(i));
        wait_cpl(c + 9);
        chk("R5", "all completions", 64'(cp_n - c), 9);
    endtask

    // Completion held under back-pressure while a lower slot finishes.
    task automatic t_cpl_stall;
        int c = cp_n;
        cpl_ready = 0;
        send_req(4'd1, 8'hA1, 40'h4_0000, 40'h5_0000, 6'd1);
        send_req(4'd2, 8'hB2, 40'h0, 40'h0, 6'd0);
        cycles(2);
        send_rsp(0, 0, 64'h1);
        cycles(3);
        chk("R5", "held valid", 64'(cpl_valid), 1);
        chk("R5", "held tag", 64'(cpl_tag), 64'hB2);
        chk("R5", "held dst", 64'(cpl_dst), 2);
        @(posedge clk); #1; cpl_ready = 1;
        wait_cpl(c + 2);
        chk("R9", "first cpl", 64'(cp_tag[c]), 64'hB2);
        chk("R9", "second cpl", 64'(cp_tag[c+1]), 64'hA1);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        t_reset();
        t_four_block();
        t_rd_stall();
        t_zero();
        t_fill();
        t_cpl_stall();
        cycles(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule